// File: doc/BRIEF.md
# Reset-Aligned Half-Rate Word Capture

This block sits between a parallel word source and a converter that is clocked by a fast update clock. The fast clock runs at twice the word rate, or at four times the word rate when the quarter-rate mode is selected. From that clock the block derives a slower strobe clock whose phase is fixed by an asynchronous reset. While reset is held, the strobe is parked high. After reset is released, the strobe starts to toggle at a known edge, so an external word source can be lined up with it.

Words are taken on the fast-clock edge on which the derived strobe rises. On that edge, the incoming word enters an input register and the word that was already held there moves on to the output register. A one-cycle capture pulse marks each such edge. The release of reset passes through a two-stage synchronizer on the fast clock. As a result, the first toggle after release always lands on a fixed edge count, and a release that arrives late relative to an edge simply counts from the following edge.

Top module: `halfrate_capture`

## Requirements
- R1: While `rst_async` is high, `phase_clk` is 1 and `cap_pulse` is 0. This takes effect without waiting for a clock edge.
- R2: While `rst_async` is high, `dout` is all zeros and no word is captured.
- R3: Count the fast rising edges after `rst_async` falls, with the first edge after the fall numbered 1. `phase_clk` stays 1 through edges 1 and 2 and falls on edge 3. In half-rate mode it rises again on edge 4.
- R4: In half-rate mode (`mode_quarter` = 0), from edge 3 onward `phase_clk` changes state on every fast rising edge.
- R5: In quarter-rate mode (`mode_quarter` = 1), `phase_clk` falls on edge 3 and rises on edge 5. After that it repeats a pattern of two edges low followed by two edges high, so a capture occurs once every four edges.
- R6: A capture happens exactly on the fast edge on which `phase_clk` goes from 0 to 1. `cap_pulse` is 1 for the single fast cycle that follows that edge and is 0 at all other times.
- R7: The word present on `din` at a capture edge appears on `dout` after the next capture edge. `dout` stays unchanged between captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast update clock |
| rst_async | input | 1 | Asynchronous reset, active high; its release is synchronized |
| mode_quarter | input | 1 | 0: strobe at half the fast rate; 1: strobe at a quarter of the fast rate |
| din | input | DATA_W | Parallel input word |
| dout | output | DATA_W | Registered word for the converter |
| phase_clk | output | 1 | Derived strobe clock, parked high in reset |
| cap_pulse | output | 1 | One fast cycle high after each capture edge |

## Verification
The assertions take `mode_quarter` to be steady whenever reset is released. They also take `din` to change away from fast rising edges, so that the word captured on an edge is the word present just before it. The stimulus changes the mode only while reset is high and drives every new word on the falling edge of the fast clock. It releases and reasserts reset at offsets of one quarter and three quarters of a period after a rising edge, so that no reset change coincides with a rising edge and the edge count after release stays deterministic.

// File: rtl/hrc_pkg.sv
`timescale 1ns/1ps
package hrc_pkg;
  // width of the phase counter that covers both divide ratios
  localparam int CNT_W = 2;

  // next counter state: a two-state loop for half rate, four states for quarter rate
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic quarter);
    if (quarter) return c + 2'd1;
    else         return {1'b0, ~c[0]};
  endfunction

  // strobe level for a counter state; state 0 is the parked-high reset state
  function automatic logic phase_of(input logic [CNT_W-1:0] c,
                                    input logic quarter);
    if (quarter) return ~(c[1] ^ c[0]);
    else         return ~c[0];
  endfunction
endpackage

// File: rtl/hrc_rst_sync.sv
`timescale 1ns/1ps
module hrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in) chain_q <= 1'b1;
        else        chain_q <= 1'b0;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b0};
      end
    end
  endgenerate

  assign rst_out = chain_q[STAGES-1];
endmodule

// File: rtl/hrc_divider.sv
`timescale 1ns/1ps
module hrc_divider
  import hrc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic quarter,
  output logic phase,
  output logic cap_fire,
  output logic cap_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             phase_q;
  logic             phase_d;
  logic             cap_q;

  always_comb begin
    cnt_d    = next_count(cnt_q, quarter);
    phase_d  = phase_of(cnt_d, quarter);
    // rising strobe edge on this clock edge
    cap_fire = phase_d & ~phase_q & ~rst;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
      cap_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      cap_q   <= cap_fire;
    end
  end

  assign phase     = phase_q;
  assign cap_pulse = cap_q;
endmodule

// File: rtl/hrc_capture.sv
`timescale 1ns/1ps
module hrc_capture #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] held_word,
  output logic [DATA_W-1:0] word_out
);
  logic [DATA_W-1:0] in_q;
  logic [DATA_W-1:0] out_q;

  // both stages advance on the same capture edge
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      in_q  <= '0;
      out_q <= '0;
    end else if (load) begin
      in_q  <= word_in;
      out_q <= in_q;
    end
  end

  assign held_word = in_q;
  assign word_out  = out_q;
endmodule

// File: rtl/halfrate_capture.sv
`timescale 1ns/1ps
module halfrate_capture #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_fast,
  input  logic              rst_async,
  input  logic              mode_quarter,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              phase_clk,
  output logic              cap_pulse
);
  // named internal events for the checker
  logic              rst_sync;
  logic              cap_fire;
  logic [DATA_W-1:0] held_word;

  hrc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_fast),
    .rst_in  (rst_async),
    .rst_out (rst_sync)
  );

  hrc_divider u_div (
    .clk       (clk_fast),
    .rst       (rst_sync),
    .quarter   (mode_quarter),
    .phase     (phase_clk),
    .cap_fire  (cap_fire),
    .cap_pulse (cap_pulse)
  );

  hrc_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk_fast),
    .rst       (rst_sync),
    .load      (cap_fire),
    .word_in   (din),
    .held_word (held_word),
    .word_out  (dout)
  );
endmodule

// File: rtl/hrc_checker.sv
`timescale 1ns/1ps
module hrc_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_sync,
  input logic              quarter,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] held_word,
  input logic [DATA_W-1:0] dout,
  input logic              phase,
  input logic              cap_pulse
);
  assert_parked_high_R1: assert property (@(posedge clk)
    rst_sync |-> (phase && !cap_pulse));

  assert_cleared_R2: assert property (@(posedge clk)
    rst_sync |-> (dout == '0 && held_word == '0));

  assert_first_fall_R3: assert property (@(posedge clk) disable iff (rst_sync)
    ($past(rst_sync) && phase) |=> !phase);

  assert_half_toggle_R4: assert property (@(posedge clk) disable iff (rst_sync)
    !quarter |=> (phase != $past(phase)));

  assert_quarter_high_two_R5: assert property (@(posedge clk) disable iff (rst_sync)
    (quarter && cap_pulse) |=> (phase && !cap_pulse));

  assert_cap_on_rise_R6: assert property (@(posedge clk) disable iff (rst_sync)
    cap_pulse |-> (phase && !$past(phase)));

  assert_word_taken_R7: assert property (@(posedge clk) disable iff (rst_sync)
    cap_pulse |-> (held_word == $past(din)));

  assert_out_steady_R7: assert property (@(posedge clk) disable iff (rst_sync)
    !cap_pulse |-> $stable(dout));
endmodule

bind halfrate_capture hrc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk_fast),
  .rst_sync  (rst_sync),
  .quarter   (mode_quarter),
  .din       (din),
  .held_word (held_word),
  .dout      (dout),
  .phase     (phase_clk),
  .cap_pulse (cap_pulse)
);

// File: tb/sim_halfrate_capture.sv
`timescale 1ns/1ps
module sim_halfrate_capture;
  localparam int  DATA_W = 12;
  localparam time CLK_P  = 10ns;

  logic              clk = 1'b0;
  logic              rst_async = 1'b1;
  logic              mode_quarter = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              phase_clk;
  logic              cap_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit released = 0;
  int edge_n = 0;
  int word_n = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic [DATA_W-1:0] last_exp = '0;

  halfrate_capture #(.DATA_W(DATA_W)) u0 (
    .clk_fast(clk), .rst_async(rst_async), .mode_quarter(mode_quarter),
    .din(din), .dout(dout), .phase_clk(phase_clk), .cap_pulse(cap_pulse)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] word_of(input int n);
    return DATA_W'((n * 157) ^ (n << 5) ^ 12'h5A3);
  endfunction

  // expected strobe level after edge e (counted from release)
  function automatic logic exp_phase(input int e, input logic q);
    int k;
    if (e <= 2) return 1'b1;
    k = e - 3;
    if (!q) return (k % 2) == 1;
    return (k % 4) >= 2;
  endfunction

  function automatic logic exp_cap(input int e, input logic q);
    if (e <= 3) return 1'b0;
    return exp_phase(e, q) && !exp_phase(e - 1, q);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s edge=%0d actual=%0h expected=%0h", req, edge_n, act, exp);
    end
  endtask

  // driver: new word each fast cycle
  task automatic drive_word();
    word_n++;
    din = word_of(word_n);
  endtask

  // scoreboard push at a capture edge, pop the word now due at the output
  task automatic push_capture(input logic [DATA_W-1:0] w);
    exp_q.push_back(w);
    last_exp = exp_q.pop_front();
  endtask

  always @(posedge clk) if (released) edge_n++;

  // monitor: samples on the falling edge, then drives the next word
  always @(negedge clk) begin
    if (!done) begin
      if (rst_async) begin
        check("R1 phase in reset", 32'(phase_clk), 32'd1);
        check("R1 cap in reset", 32'(cap_pulse), 32'd0);
        check("R2 dout in reset", 32'(dout), 32'd0);
      end else if (released) begin
        if (exp_cap(edge_n, mode_quarter)) push_capture(din_at_edge);
        check(mode_quarter ? "R5 phase" : (edge_n <= 4 ? "R3 phase" : "R4 phase"),
              32'(phase_clk), 32'(exp_phase(edge_n, mode_quarter)));
        check("R6 cap_pulse", 32'(cap_pulse), 32'(exp_cap(edge_n, mode_quarter)));
        check("R7 dout", 32'(dout), 32'(last_exp));
      end
      din_at_edge = din;
      drive_word();
      din_at_edge_next = din;
    end
  end

  // din held at the next rising edge is the word driven at this falling edge
  logic [DATA_W-1:0] din_at_edge = '0;
  logic [DATA_W-1:0] din_at_edge_next = '0;
  always @(posedge clk) din_at_edge = din_at_edge_next;

  task automatic release_at(input time offset, input logic q);
    mode_quarter = q;
    @(posedge clk);
    #(offset);
    exp_q.delete();
    exp_q.push_back('0);
    last_exp = '0;
    edge_n = 0;
    rst_async = 1'b0;
    released = 1'b1;
  endtask

  task automatic assert_reset(input int cycles);
    @(posedge clk);
    #(CLK_P/4);
    rst_async = 1'b1;
    released = 1'b0;
    repeat (cycles) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    release_at(CLK_P/4, 1'b0);            // R3 R4 half rate, early release
    repeat (40) @(posedge clk);
    assert_reset(3);                      // R1 R2 mid-run async reset
    release_at(3*CLK_P/4, 1'b0);          // R3 late-in-cycle release
    repeat (30) @(posedge clk);
    assert_reset(4);
    release_at(CLK_P/4, 1'b1);            // R5 quarter rate
    repeat (60) @(posedge clk);
    assert_reset(2);
    release_at(3*CLK_P/4, 1'b1);          // R5 late release
    repeat (33) @(posedge clk);
    assert_reset(3);
    release_at(CLK_P/4, 1'b0);            // R4 back to half rate
    repeat (25) @(posedge clk);
    #(CLK_P/4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule